// File: doc/BRIEF.md
# Next-PC and Micro-op Sequencer

This block holds the fetch program-counter state of one thread and works out the state that follows each fetched instruction. The state has three fields: the address being fetched (`cur_pc`), the address after it (`cur_npc`), and the micro-op index inside the current macro-instruction (`cur_uidx`). Each cycle the fetch stage supplies the flags of the instruction it is fetching and the prediction for it: whether it is a control instruction, whether it is a micro-op, whether it is the final micro-op of its macro-instruction, a taken bit and a target address.

When `advance` is high, the register takes the computed state at the clock edge. A non-control micro-op that is not the final one only steps the micro-op index. Every other instruction moves on to a new address and clears the index. A control instruction follows the prediction. The `DELAY_SLOT` parameter selects one of two branch rules. With it set, the instruction after a branch always runs, and the predicted target goes into the next-PC field. With it clear, the target goes straight into the PC.

A squash loads all three fields from the redirect inputs. It wins over normal sequencing and takes effect even when `advance` is low. The block drives `pred_taken_out` for the instruction being fetched. It also drives `branching`, which flags that the held next PC does not follow on sequentially from the held PC.

Top module: `npc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `cur_pc` to `RESET_VEC`, `cur_npc` to `RESET_VEC + INST_BYTES` and `cur_uidx` to 0.
- R2: With `advance` high and no squash, a non-control instruction with `is_uop`=1 and `is_last_uop`=0 increments `cur_uidx` by one, wrapping modulo 2^UIDX_W. `cur_pc` and `cur_npc` do not change.
- R3: With `advance` high and no squash, any other non-control instruction sets `cur_pc` to the old `cur_npc`, sets `cur_npc` to the old `cur_npc + INST_BYTES`, and clears `cur_uidx` to 0.
- R4: With `advance` high and no squash, a control instruction (`is_ctrl`=1) clears `cur_uidx` to 0, whatever the micro-op flags are.
- R5: With `DELAY_SLOT`=0, an advanced control instruction sets `cur_pc` to `pred_target` if `pred_taken_in` is 1, and to the old `cur_pc + INST_BYTES` if it is 0. `cur_npc` becomes the new `cur_pc + INST_BYTES`.
- R6: With `DELAY_SLOT`=1, an advanced control instruction sets `cur_pc` to the old `cur_npc`. `cur_npc` becomes `pred_target` if `pred_taken_in` is 1, and the old `cur_npc + INST_BYTES` if it is 0.
- R7: `pred_taken_out` is combinational and equals `is_ctrl & pred_taken_in`, so it is 0 for every non-control instruction.
- R8: `squash` high at a rising edge loads `redir_pc`, `redir_npc` and `redir_uidx` into the three state fields, whatever `advance` and the instruction flags are.
- R9: With `squash` and `advance` both low, the state does not change.
- R10: `branching` is 1 exactly when `cur_npc` is not equal to `cur_pc + INST_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Take the sequenced state at this edge |
| is_ctrl | input | 1 | Current instruction is a control instruction |
| is_uop | input | 1 | Current instruction is a micro-op |
| is_last_uop | input | 1 | Current micro-op is the final one of its macro-instruction |
| pred_taken_in | input | 1 | Predictor says taken |
| pred_target | input | ADDR_W | Predicted target address |
| squash | input | 1 | Load the redirect state |
| redir_pc | input | ADDR_W | Redirect PC |
| redir_npc | input | ADDR_W | Redirect next PC |
| redir_uidx | input | UIDX_W | Redirect micro-op index |
| cur_pc | output | ADDR_W | Held PC |
| cur_npc | output | ADDR_W | Held next PC |
| cur_uidx | output | UIDX_W | Held micro-op index |
| pred_taken_out | output | 1 | Taken flag passed on for the current instruction |
| branching | output | 1 | Held next PC is not sequential to the held PC |

## Verification
Two instances, one for each `DELAY_SLOT` setting, receive the same random stream of flag combinations, taken bits and targets, with occasional squashes and idle cycles. Both are compared every cycle against a model in the bench, so a taken branch separates the two target rules and a not-taken branch shows whether the wrong base address is incremented. Directed runs of middle micro-ops, a last micro-op, a control instruction in the middle of a micro-op run, and a squash while `advance` is low show index stepping apart from address stepping, and show squash priority apart from holding.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int ADDR_W = 32;
    localparam int UIDX_W = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [UIDX_W-1:0] uidx;
    } pc_state_t;
endpackage

// File: rtl/npc_linear_step.sv
module npc_linear_step
    import npc_pkg::*;
#(
    parameter int INST_BYTES = 4
) (
    input  pc_state_t st_i,
    input  logic      is_uop_i,
    input  logic      is_last_uop_i,
    output pc_state_t st_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    logic mid_uop;

    always_comb begin
        mid_uop = is_uop_i && !is_last_uop_i;
        if (mid_uop) begin
            st_o      = st_i;
            st_o.uidx = st_i.uidx + UIDX_W'(1);
        end else begin
            st_o.pc   = st_i.npc;
            st_o.npc  = st_i.npc + STEP;
            st_o.uidx = '0;
        end
    end
endmodule

// File: rtl/npc_branch_step.sv
module npc_branch_step
    import npc_pkg::*;
#(
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  pc_state_t         st_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] target_i,
    output pc_state_t         st_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    generate
        if (DELAY_SLOT) begin : g_slot
            always_comb begin
                st_o.pc   = st_i.npc;
                st_o.npc  = taken_i ? target_i : (st_i.npc + STEP);
                st_o.uidx = '0;
            end
        end else begin : g_noslot
            logic [ADDR_W-1:0] new_pc;
            always_comb begin
                new_pc    = taken_i ? target_i : (st_i.pc + STEP);
                st_o.pc   = new_pc;
                st_o.npc  = new_pc + STEP;
                st_o.uidx = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
    import npc_pkg::*;
#(
    parameter int                INST_BYTES = 4,
    parameter bit                DELAY_SLOT = 1'b0,
    parameter logic [ADDR_W-1:0] RESET_VEC  = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              is_ctrl,
    input  logic              is_uop,
    input  logic              is_last_uop,
    input  logic              pred_taken_in,
    input  logic [ADDR_W-1:0] pred_target,
    input  logic              squash,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic [ADDR_W-1:0] redir_npc,
    input  logic [UIDX_W-1:0] redir_uidx,
    output logic [ADDR_W-1:0] cur_pc,
    output logic [ADDR_W-1:0] cur_npc,
    output logic [UIDX_W-1:0] cur_uidx,
    output logic              pred_taken_out,
    output logic              branching
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    pc_state_t st_q, st_d;
    pc_state_t lin_st, br_st;

    npc_linear_step #(.INST_BYTES(INST_BYTES)) u_linear (
        .st_i          (st_q),
        .is_uop_i      (is_uop),
        .is_last_uop_i (is_last_uop),
        .st_o          (lin_st)
    );

    npc_branch_step #(.INST_BYTES(INST_BYTES), .DELAY_SLOT(DELAY_SLOT)) u_branch (
        .st_i     (st_q),
        .taken_i  (pred_taken_in),
        .target_i (pred_target),
        .st_o     (br_st)
    );

    always_comb begin
        st_d = st_q;
        if (squash) begin
            st_d.pc   = redir_pc;
            st_d.npc  = redir_npc;
            st_d.uidx = redir_uidx;
        end else if (advance) begin
            st_d = is_ctrl ? br_st : lin_st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc   <= RESET_VEC;
            st_q.npc  <= RESET_VEC + STEP;
            st_q.uidx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_pc         = st_q.pc;
    assign cur_npc        = st_q.npc;
    assign cur_uidx       = st_q.uidx;
    assign pred_taken_out = is_ctrl & pred_taken_in;
    assign branching      = (st_q.npc != (st_q.pc + STEP));

    p_squash_load_r8: assert property (@(posedge clk) disable iff (rst)
        squash |=> (cur_pc == $past(redir_pc) && cur_npc == $past(redir_npc)
                    && cur_uidx == $past(redir_uidx)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!squash && !advance) |=> ($stable(cur_pc) && $stable(cur_npc) && $stable(cur_uidx)));

    p_uop_step_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !squash && !is_ctrl && is_uop && !is_last_uop)
        |=> (cur_uidx == $past(cur_uidx) + UIDX_W'(1) && $stable(cur_pc) && $stable(cur_npc)));

    p_ctrl_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !squash && is_ctrl) |=> (cur_uidx == '0));

    p_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !squash && !is_ctrl && !(is_uop && !is_last_uop))
        |=> (cur_pc == $past(cur_npc) && cur_uidx == '0));

    always_comb begin
        p_taken_gate_r7: assert (!(pred_taken_out && !is_ctrl));
    end
endmodule

// File: tb/tb_npc_sequencer.sv
module tb_npc_sequencer;
    import npc_pkg::*;

    localparam int                IB   = 4;
    localparam logic [ADDR_W-1:0] RV   = 32'h0000_1000;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(IB);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, advance, is_ctrl, is_uop, is_last_uop, pred_taken_in, squash;
    logic [ADDR_W-1:0] pred_target, redir_pc, redir_npc;
    logic [UIDX_W-1:0] redir_uidx;
    logic [ADDR_W-1:0] pc0, npc0, pc1, npc1;
    logic [UIDX_W-1:0] ui0, ui1;
    logic pt0, pt1, br0, br1;

    npc_sequencer #(.INST_BYTES(IB), .DELAY_SLOT(1'b0), .RESET_VEC(RV)) dut (
        .clk(clk), .rst(rst), .advance(advance), .is_ctrl(is_ctrl), .is_uop(is_uop),
        .is_last_uop(is_last_uop), .pred_taken_in(pred_taken_in), .pred_target(pred_target),
        .squash(squash), .redir_pc(redir_pc), .redir_npc(redir_npc), .redir_uidx(redir_uidx),
        .cur_pc(pc0), .cur_npc(npc0), .cur_uidx(ui0), .pred_taken_out(pt0), .branching(br0));

    npc_sequencer #(.INST_BYTES(IB), .DELAY_SLOT(1'b1), .RESET_VEC(RV)) dut_ds (
        .clk(clk), .rst(rst), .advance(advance), .is_ctrl(is_ctrl), .is_uop(is_uop),
        .is_last_uop(is_last_uop), .pred_taken_in(pred_taken_in), .pred_target(pred_target),
        .squash(squash), .redir_pc(redir_pc), .redir_npc(redir_npc), .redir_uidx(redir_uidx),
        .cur_pc(pc1), .cur_npc(npc1), .cur_uidx(ui1), .pred_taken_out(pt1), .branching(br1));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [ADDR_W-1:0] m_pc [2];
    logic [ADDR_W-1:0] m_npc[2];
    logic [UIDX_W-1:0] m_ui [2];

    function automatic void model_next(input bit ds);
        int k;
        logic [ADDR_W-1:0] p, n, np;
        logic [UIDX_W-1:0] u;
        k = ds ? 1 : 0;
        p = m_pc[k]; n = m_npc[k]; u = m_ui[k];
        if (squash) begin
            p = redir_pc; n = redir_npc; u = redir_uidx;
        end else if (advance) begin
            if (!is_ctrl) begin
                if (is_uop && !is_last_uop) u = u + UIDX_W'(1);
                else begin p = n; n = n + STEP; u = '0; end
            end else begin
                u = '0;
                if (ds) begin
                    np = n;
                    n  = pred_taken_in ? pred_target : n + STEP;
                    p  = np;
                end else begin
                    p = pred_taken_in ? pred_target : p + STEP;
                    n = p + STEP;
                end
            end
        end
        m_pc[k] = p; m_npc[k] = n; m_ui[k] = u;
    endfunction

    task automatic chk(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R5 pc"},      pc0, m_pc[0]);
        chk({tag, " R5 npc"},     npc0, m_npc[0]);
        chk({tag, " R2 uidx"},    ADDR_W'(ui0), ADDR_W'(m_ui[0]));
        chk({tag, " R6 pc ds"},   pc1, m_pc[1]);
        chk({tag, " R6 npc ds"},  npc1, m_npc[1]);
        chk({tag, " R4 uidx ds"}, ADDR_W'(ui1), ADDR_W'(m_ui[1]));
        chk({tag, " R10 br"},     ADDR_W'(br0), ADDR_W'(m_npc[0] != m_pc[0] + STEP));
        chk({tag, " R10 br ds"},  ADDR_W'(br1), ADDR_W'(m_npc[1] != m_pc[1] + STEP));
    endtask

    task automatic step(input logic a, input logic c, input logic u, input logic l,
                        input logic t, input logic [ADDR_W-1:0] tgt, input logic s,
                        input string tag);
        @(negedge clk);
        advance = a; is_ctrl = c; is_uop = u; is_last_uop = l;
        pred_taken_in = t; pred_target = tgt; squash = s;
        #1;
        chk({tag, " R7 taken"},    ADDR_W'(pt0), ADDR_W'(c & t));
        chk({tag, " R7 taken ds"}, ADDR_W'(pt1), ADDR_W'(c & t));
        model_next(1'b0);
        model_next(1'b1);
        @(posedge clk);
        #1;
        check_state(tag);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; advance = 0; is_ctrl = 0; is_uop = 0; is_last_uop = 0;
        pred_taken_in = 0; pred_target = '0; squash = 0;
        redir_pc = '0; redir_npc = '0; redir_uidx = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 2; k++) begin m_pc[k] = RV; m_npc[k] = RV + STEP; m_ui[k] = '0; end
        check_state("R1 reset");

        step(1, 0, 0, 0, 0, '0, 0, "R3 seq");
        step(1, 0, 1, 0, 0, '0, 0, "R2 uop");
        step(1, 0, 1, 0, 0, '0, 0, "R2 uop");
        step(1, 1, 1, 0, 1, 32'h0000_8000, 0, "R4 ctrl mid uop");
        step(1, 0, 1, 0, 0, '0, 0, "R2 uop");
        step(1, 0, 1, 1, 0, '0, 0, "R3 last uop");
        step(1, 1, 0, 0, 0, 32'h0000_9000, 0, "R5 R6 not taken");
        step(1, 1, 0, 0, 1, 32'h0000_A000, 0, "R5 R6 taken");
        step(0, 1, 0, 0, 1, 32'h0000_B000, 0, "R9 hold");
        redir_pc = 32'h0000_2000; redir_npc = 32'h0000_2010; redir_uidx = 3'd5;
        step(0, 0, 0, 0, 0, '0, 1, "R8 squash idle");
        step(1, 1, 0, 0, 1, 32'h0000_C000, 1, "R8 squash wins");
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 0, '0, 0, "R2 wrap");

        for (int i = 0; i < 3000; i++) begin
            logic s;
            s = ($urandom % 20) == 0;
            redir_pc   = $urandom & 32'hFFFF_FFFC;
            redir_npc  = $urandom & 32'hFFFF_FFFC;
            redir_uidx = UIDX_W'($urandom);
            step(($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom & 32'hFFFF_FFFC, s, "rand R2 R3 R4 R5 R6 R8 R9");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule